// File: doc/BRIEF.md
# Video Field Capture to SRAM

This block watches an 8-bit component video byte stream, one byte per pixel clock, and copies the active picture samples of a single field into an external asynchronous SRAM. Timing reference codes are embedded in the stream. Each one is a three-byte preamble followed by a status byte. The block uses these codes to tell blanking lines from picture lines and to find the end of the field. The status codes it recognises are 0x00 (picture data follows), 0x20 (a blanking line follows) and 0x70 (the field has ended).

Software or a host controller arms a capture by raising `cap_en` in the system clock domain. The block then starts a new field at SRAM address zero. It skips bytes until a picture-start code, stores every picture byte in arrival order, skips blanking lines, and stops at the end-of-field code. At that point `field_done` goes high in the system domain and stays high until `cap_en` is lowered. A malformed timing code gives a one-cycle pulse on `fmt_err`.

A capture state machine controls the flow:
- It leaves IDLE for BLANK on arming; this is the "start" transition, and it clears the address.
- It moves from BLANK to ACTIVE on a 0x00 code ("line open").
- It moves from ACTIVE back to BLANK on a 0x20 code ("line skip").
- It moves from BLANK or ACTIVE to DONE on a 0x70 code ("field end").
- It returns from any state to IDLE when the arm is dropped ("abort/release").

Top module: `vfc_capture_top`

## Requirements
- R1: After reset, `sram_ce_n`, `sram_we_n` and `sram_oe_n` are high, and `fmt_err` and `field_done` are low.
- R2: A timing code is the bytes 0xFF, 0x00, 0x00 and then a status byte, on consecutive pixel clocks. After status 0x00, every following byte is stored, in order, until the next timing code. The preamble bytes and the status bytes themselves are never stored.
- R3: Status 0x20 puts the block into blanking. No byte is stored until the next 0x00 code. Bytes that arrive after arming but before the first 0x00 code are not stored either.
- R4: Status 0x70 ends the field. No byte after it is stored, even after a later 0x00 code. `field_done` goes high and stays high until `cap_en` is low.
- R5: While `cap_en` is low, no SRAM write occurs, whatever the stream contains.
- R6: The first byte stored after `cap_en` rises goes to address 0. Each later stored byte goes to the next address (previous + 1).
- R7: Once the address reaches 2^ADDR_W-1, further stored bytes reuse that top address.
- R8: Each stored byte drives `sram_ce_n` and `sram_we_n` low together for one pixel clock, and `sram_oe_n` stays high. `sram_addr` and `sram_dq` change only at a store edge.
- R9: If 0xFF, 0x00 is followed by a byte other than 0x00, `fmt_err` pulses high for one cycle.
- R10: A status byte other than 0x00, 0x20 or 0x70 pulses `fmt_err` high for one cycle. It changes no capture state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the stream, SRAM strobes and `fmt_err` are on this clock |
| sys_clk | input | 1 | System clock; `cap_en` and `field_done` are on this clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| cap_en | input | 1 | Capture arm, system domain; high lets one field be captured |
| pix_data | input | 8 | Video byte stream |
| sram_addr | output | ADDR_W (19) | SRAM write address |
| sram_dq | output | 8 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low, held high |
| sram_we_n | output | 1 | SRAM write enable, active low |
| fmt_err | output | 1 | One-cycle pulse on a malformed timing code |
| field_done | output | 1 | End of field reached, system domain |

## Verification
The assertions check four things on every cycle:
- consecutive stores step the address by one, or hold it at the top;
- address and data stay put when no store happens;
- no store happens while disarmed or after the end-of-field code;
- an error pulse always follows a non-zero byte.

Only the bench scenarios can show which bytes are stored, in what order, and to which absolute address. They also cover removing the preamble bytes, skipping blanking lines, restarting at zero on re-arming, and saturating a narrow address counter. These checks rely on a behavioural model of the stream that predicts each stored byte and each error pulse.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    localparam int BYTE_W  = 8;
    localparam int PRE_LEN = 3;

    localparam logic [BYTE_W-1:0] SYNC_HI  = 8'hFF;
    localparam logic [BYTE_W-1:0] SYNC_LO  = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_SAV = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_VBL = 8'h20;
    localparam logic [BYTE_W-1:0] CODE_EOF = 8'h70;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_BLANK,
        CAP_ACTIVE,
        CAP_DONE
    } cap_state_t;

    typedef enum logic [1:0] {
        PH_NONE,
        PH_HI,
        PH_HI_LO,
        PH_HI_LO_LO
    } pre_phase_t;

    typedef enum logic [1:0] {
        TRS_SAV,
        TRS_VBL,
        TRS_EOF,
        TRS_BAD
    } trs_kind_t;

endpackage

// File: rtl/vfc_sync2.sv
module vfc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/vfc_trs_detect.sv
module vfc_trs_detect
    import vfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              hit_o,
    output trs_kind_t         kind_o,
    output logic              err_o
);
    pre_phase_t ph_q;
    pre_phase_t ph_d;
    logic       err_d;

    // classify the current byte as a status code
    always_comb begin
        unique case (byte_i)
            CODE_SAV: kind_o = TRS_SAV;
            CODE_VBL: kind_o = TRS_VBL;
            CODE_EOF: kind_o = TRS_EOF;
            default:  kind_o = TRS_BAD;
        endcase
    end

    // preamble tracker
    always_comb begin
        ph_d  = ph_q;
        err_d = 1'b0;
        hit_o = (ph_q == PH_HI_LO_LO);
        unique case (ph_q)
            PH_NONE: begin
                ph_d = (byte_i == SYNC_HI) ? PH_HI : PH_NONE;
            end
            PH_HI: begin
                if (byte_i == SYNC_LO)      ph_d = PH_HI_LO;
                else if (byte_i == SYNC_HI) ph_d = PH_HI;
                else                        ph_d = PH_NONE;
            end
            PH_HI_LO: begin
                if (byte_i == SYNC_LO) begin
                    ph_d = PH_HI_LO_LO;
                end else begin
                    err_d = 1'b1;
                    ph_d  = (byte_i == SYNC_HI) ? PH_HI : PH_NONE;
                end
            end
            PH_HI_LO_LO: begin
                ph_d  = PH_NONE;
                err_d = (kind_o == TRS_BAD);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_NONE;
            err_o <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            err_o <= err_d;
        end
    end
endmodule

// File: rtl/vfc_capture_fsm.sv
module vfc_capture_fsm
    import vfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_i,
    input  logic       hit_i,
    input  trs_kind_t  kind_i,
    output logic       start_o,
    output logic       cand_o,
    output logic       done_o,
    output cap_state_t state_o
);
    cap_state_t state_q;
    cap_state_t state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: begin
                if (arm_i) state_d = CAP_BLANK;
            end
            CAP_BLANK: begin
                if (!arm_i)                           state_d = CAP_IDLE;
                else if (hit_i && kind_i == TRS_SAV)  state_d = CAP_ACTIVE;
                else if (hit_i && kind_i == TRS_EOF)  state_d = CAP_DONE;
            end
            CAP_ACTIVE: begin
                if (!arm_i)                           state_d = CAP_IDLE;
                else if (hit_i && kind_i == TRS_VBL)  state_d = CAP_BLANK;
                else if (hit_i && kind_i == TRS_EOF)  state_d = CAP_DONE;
            end
            CAP_DONE: begin
                if (!arm_i) state_d = CAP_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        start_o = (state_q == CAP_IDLE) && arm_i;
        cand_o  = (state_q == CAP_ACTIVE) && !hit_i;
        done_o  = (state_q == CAP_DONE);
        state_o = state_q;
    end
endmodule

// File: rtl/vfc_store_path.sv
module vfc_store_path
    import vfc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              cand_i,
    input  logic              cancel_i,
    input  logic              arm_i,
    input  logic              restart_i,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [BYTE_W-1:0] sram_dq_o,
    output logic              sram_ce_n_o,
    output logic              sram_oe_n_o,
    output logic              sram_we_n_o
);
    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};
    localparam int                LAST     = PRE_LEN - 1;

    logic [PRE_LEN-1:0] dly_v;
    logic [BYTE_W-1:0]  dly_d [PRE_LEN];
    logic [ADDR_W-1:0]  cnt_q;
    logic               we_q;
    logic               wr_now;

    assign wr_now = dly_v[LAST] && !cancel_i && arm_i;

    // holding line: bytes wait here until it is known they are not a preamble
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_v[0] <= 1'b0;
            dly_d[0] <= '0;
        end else begin
            dly_v[0] <= cand_i && arm_i;
            dly_d[0] <= byte_i;
        end
    end

    for (genvar g = 1; g < PRE_LEN; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dly_v[g] <= 1'b0;
                dly_d[g] <= '0;
            end else begin
                dly_v[g] <= dly_v[g-1] && !cancel_i && arm_i;
                dly_d[g] <= dly_d[g-1];
            end
        end
    end

    // address counter and SRAM output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            we_q        <= 1'b0;
            sram_addr_o <= '0;
            sram_dq_o   <= '0;
        end else begin
            we_q <= wr_now;
            if (restart_i) begin
                cnt_q <= '0;
            end else if (wr_now) begin
                sram_addr_o <= cnt_q;
                sram_dq_o   <= dly_d[LAST];
                if (cnt_q != ADDR_TOP) cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sram_ce_n_o = !we_q;
    assign sram_we_n_o = !we_q;
    assign sram_oe_n_o = 1'b1;
endmodule

// File: rtl/vfc_capture_top.sv
module vfc_capture_top
    import vfc_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              pix_clk,
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [7:0]        pix_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [7:0]        sram_dq,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              fmt_err,
    output logic              field_done
);
    logic [BYTE_W-1:0] din_q;
    logic              arm_s;
    logic              trs_hit;
    trs_kind_t         trs_kind;
    logic              cap_start;
    logic              cap_cand;
    logic              done_pix;
    cap_state_t        cap_state;

    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= pix_data;
    end

    vfc_sync2 #(.W(1)) u_arm_sync (
        .clk   (pix_clk),
        .rst_n (rst_n),
        .d     (cap_en),
        .q     (arm_s)
    );

    vfc_trs_detect u_trs (
        .clk    (pix_clk),
        .rst_n  (rst_n),
        .byte_i (din_q),
        .hit_o  (trs_hit),
        .kind_o (trs_kind),
        .err_o  (fmt_err)
    );

    vfc_capture_fsm u_fsm (
        .clk     (pix_clk),
        .rst_n   (rst_n),
        .arm_i   (arm_s),
        .hit_i   (trs_hit),
        .kind_i  (trs_kind),
        .start_o (cap_start),
        .cand_o  (cap_cand),
        .done_o  (done_pix),
        .state_o (cap_state)
    );

    vfc_store_path #(.ADDR_W(ADDR_W)) u_store (
        .clk         (pix_clk),
        .rst_n       (rst_n),
        .byte_i      (din_q),
        .cand_i      (cap_cand),
        .cancel_i    (trs_hit),
        .arm_i       (arm_s),
        .restart_i   (cap_start),
        .sram_addr_o (sram_addr),
        .sram_dq_o   (sram_dq),
        .sram_ce_n_o (sram_ce_n),
        .sram_oe_n_o (sram_oe_n),
        .sram_we_n_o (sram_we_n)
    );

    vfc_sync2 #(.W(1)) u_done_sync (
        .clk   (sys_clk),
        .rst_n (rst_n),
        .d     (done_pix),
        .q     (field_done)
    );
endmodule

// File: rtl/vfc_capture_chk.sv
module vfc_capture_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              done_pix,
    input logic [7:0]        din,
    input logic [ADDR_W-1:0] sram_addr,
    input logic [7:0]        sram_dq,
    input logic              sram_we_n,
    input logic              fmt_err
);
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |->
        ((sram_addr == ADDR_W'($past(sram_addr) + 1)) || ((&sram_addr) && (&$past(sram_addr))))); // R6

    AST_ADDR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && (&$past(sram_addr)) && $past(!sram_we_n)) |-> (&sram_addr)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_n |-> ($stable(sram_addr) && $stable(sram_dq))); // R8

    AST_NO_WRITE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> sram_we_n); // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_pix |-> sram_we_n); // R4

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> ($past(din) != 8'h00)); // R9
endmodule

bind vfc_capture_top vfc_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (pix_clk),
    .rst_n     (rst_n),
    .arm       (arm_s),
    .done_pix  (done_pix),
    .din       (din_q),
    .sram_addr (sram_addr),
    .sram_dq   (sram_dq),
    .sram_we_n (sram_we_n),
    .fmt_err   (fmt_err)
);

// File: tb/sim_vfc_capture_top.sv
`timescale 1ns/1ps
module sim_vfc_capture_top;
    localparam int AW0 = 19;
    localparam int AW1 = 3;
    localparam int TOP1 = (1 << AW1) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cap_en = 1'b0;
    logic [7:0] pix_data = 8'h10;

    logic [AW0-1:0] addr0;
    logic [7:0] dq0;
    logic ce0, oe0, we0, err0, done0;
    logic [AW1-1:0] addr1;
    logic [7:0] dq1;
    logic ce1, oe1, we1, err1, done1;

    always #5 clk = ~clk;

    vfc_capture_top #(.ADDR_W(AW0)) u0 (
        .pix_clk(clk), .sys_clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pix_data(pix_data),
        .sram_addr(addr0), .sram_dq(dq0), .sram_ce_n(ce0), .sram_oe_n(oe0), .sram_we_n(we0),
        .fmt_err(err0), .field_done(done0));

    vfc_capture_top #(.ADDR_W(AW1)) u1 (
        .pix_clk(clk), .sys_clk(clk), .rst_n(rst_n), .cap_en(cap_en), .pix_data(pix_data),
        .sram_addr(addr1), .sram_dq(dq1), .sram_ce_n(ce1), .sram_oe_n(oe1), .sram_we_n(we1),
        .fmt_err(err1), .field_done(done1));

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wr_count = 0;
    int err_seen = 0;
    bit mon_on = 1'b0;
    logic [AW0-1:0] last_addr0 = '0;
    logic [7:0] last_dq0 = '0;

    // behavioural stream model
    int mode = 0;          // 0 idle, 1 blanking, 2 picture, 3 finished
    int ph = 0;            // preamble bytes seen so far
    int cnt = 0;           // stored-byte count of the current field
    int exp_err = 0;
    int q0[$];
    int q1[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        pix_data = b;
        if (ph == 3) begin
            if (mode == 2) begin
                for (int k = 0; k < 3; k++) begin
                    void'(q0.pop_back());
                    void'(q1.pop_back());
                    cnt--;
                end
            end
            if (b != 8'h00 && b != 8'h20 && b != 8'h70) exp_err++;
            else if (mode == 1 || mode == 2) begin
                if (b == 8'h00) mode = 2;
                else if (b == 8'h20) mode = 1;
                else mode = 3;
            end
            ph = 0;
        end else begin
            if (mode == 2) begin
                q0.push_back(cnt * 256 + int'(b));
                q1.push_back(cnt * 256 + int'(b));
                cnt++;
            end
            if (ph == 0) ph = (b == 8'hFF) ? 1 : 0;
            else if (ph == 1) ph = (b == 8'h00) ? 2 : ((b == 8'hFF) ? 1 : 0);
            else begin
                if (b == 8'h00) ph = 3;
                else begin
                    exp_err++;
                    ph = (b == 8'hFF) ? 1 : 0;
                end
            end
        end
    endtask

    task automatic send_code(input logic [7:0] st);
        send(8'hFF); send(8'h00); send(8'h00); send(st);
    endtask

    task automatic send_run(input logic [7:0] first, input int n);
        for (int i = 0; i < n; i++) send(first + 8'(i));
    endtask

    task automatic set_cap(input bit v);
        cap_en = v;
        if (v && mode == 0) begin
            mode = 1;
            cnt = 0;
        end
        if (!v) mode = 0;
        for (int i = 0; i < 6; i++) send(8'h10);
    endtask

    task automatic settle();
        for (int i = 0; i < 10; i++) send(8'h10);
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (mon_on) begin
            check(oe0 == 1'b1 && oe1 == 1'b1, "R8 oe high", int'(oe0), 1);
            check(ce0 == we0, "R8 ce/we paired", int'(ce0), int'(we0));
            if (!we0) begin
                wr_count++;
                if (q0.size() == 0) begin
                    check(1'b0, "R5 unexpected store", int'(addr0), -1);
                end else begin
                    int e;
                    e = q0.pop_front();
                    check(int'(addr0) == e / 256, "R6 address", int'(addr0), e / 256);
                    check(int'(dq0) == e % 256, "R2 data", int'(dq0), e % 256);
                end
                last_addr0 = addr0;
                last_dq0 = dq0;
            end else begin
                check(addr0 == last_addr0 && dq0 == last_dq0, "R8 hold", int'(addr0), int'(last_addr0));
            end
            if (!we1) begin
                if (q1.size() == 0) begin
                    check(1'b0, "R7 unexpected store", int'(addr1), -1);
                end else begin
                    int e;
                    int ea;
                    e = q1.pop_front();
                    ea = (e / 256 > TOP1) ? TOP1 : e / 256;
                    check(int'(addr1) == ea, "R7 saturating address", int'(addr1), ea);
                end
            end
            if (err0) err_seen++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ce0 && we0 && oe0, "R1 strobes idle", int'({ce0, we0, oe0}), 7);
        check(!err0 && !done0, "R1 flags low", int'({err0, done0}), 0);
        mon_on = 1'b1;

        // field A: junk, two blanking lines, one picture line, end of field
        set_cap(1'b1);
        base = wr_count;
        send_run(8'hA0, 5);
        send_code(8'h20); send_run(8'h50, 3);
        send_code(8'h20);
        send_code(8'h00); send_run(8'h01, 44);
        send_code(8'h70);
        settle();
        check(wr_count - base == 44, "R2 store count field A", wr_count - base, 44);
        check(q0.size() == 0, "R2 all bytes stored", q0.size(), 0);
        check(done0 == 1'b1, "R4 field_done high", int'(done0), 1);
        // data after the end code must not be stored
        base = wr_count;
        send_code(8'h00); send_run(8'h80, 6);
        settle();
        check(wr_count == base, "R4 no store after end", wr_count - base, 0);
        check(done0 == 1'b1, "R4 field_done held", int'(done0), 1);
        set_cap(1'b0);
        settle();
        check(done0 == 1'b0, "R4 field_done released", int'(done0), 0);

        // field B: re-armed, blanking line in the middle, address restarts
        set_cap(1'b1);
        base = wr_count;
        send_code(8'h00); send_run(8'hC0, 8);
        send_code(8'h20); send_run(8'hE0, 4);
        send_code(8'h00); send_run(8'hD0, 8);
        send_code(8'h70);
        settle();
        check(wr_count - base == 16, "R3 blanking line skipped", wr_count - base, 16);
        check(q0.size() == 0, "R6 restart at zero consumed", q0.size(), 0);
        set_cap(1'b0);

        // malformed codes while idle
        err_seen = 0;
        exp_err = 0;
        send(8'hFF); send(8'h00); send(8'h05);
        settle();
        check(err_seen == 1, "R9 bad third byte", err_seen, 1);
        send_code(8'h33);
        settle();
        check(err_seen == 2, "R10 bad status", err_seen, 2);
        check(exp_err == err_seen, "R10 model agreement", err_seen, exp_err);

        // whole field while disarmed
        base = wr_count;
        send_code(8'h20);
        send_code(8'h00); send_run(8'h30, 12);
        send_code(8'h70);
        settle();
        check(wr_count == base, "R5 no store while disarmed", wr_count - base, 0);
        check(done0 == 1'b0, "R5 no field_done while disarmed", int'(done0), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule